// File: doc/BRIEF.md
# Transparent March Self-Test Controller for Word RAM

This controller runs a March C style self-test on a word-organised RAM and leaves the RAM holding exactly what it held before. No data pattern is written. Each write places the complement of the word just read, or puts back the word's original value. Every word is inverted four times in total, so it ends where it began. The read data of the RAM is folded into a multiple-input signature register (MISR).

A test has two passes over the same operation sequence:

- **Pass one** keeps the write enable low. It corrects each read word by the inversion that pass two would expect at that point. The resulting signature is the prediction.
- **Pass two** performs the real reads and writes and compresses the raw read data.

A mismatch between the two signatures raises `fail`. The system pulses `start` while the RAM is otherwise quiet. It then watches `busy` fall and `done` rise.

The operation sequence, with v the stored word, ~v its complement and addresses ascending unless noted:

| Element | Address order | Operations |
|---|---|---|
| E0 | ascending | read v |
| E1 | ascending | read v, write ~v |
| E2 | ascending | read ~v, write v |
| E3 | descending | read v, write ~v |
| E4 | descending | read ~v, write v |
| E5 | ascending | read v |

The state machine has four states:

- `ST_IDLE` — waiting for `start`.
- `ST_READ` — one read cycle.
- `ST_WRITE` — one write cycle, whose write enable is held low in pass one.
- `ST_PASSEND` — the gap between passes, and the final compare.

Its transitions are:

- **launch**: `ST_IDLE` to `ST_READ` when `start` is seen.
- **pair**: `ST_READ` to `ST_WRITE` in elements that write.
- **advance**: to `ST_READ` at the next address, or at the first address of the next element.
- **pass over**: to `ST_PASSEND` after the last operation of E5.
- **rerun**: `ST_PASSEND` to `ST_READ` after pass one.
- **finish**: `ST_PASSEND` to `ST_IDLE` after pass two.

Top module: `tmarch_bist`

## Requirements
- R1: After reset, `busy`, `done`, `fail` and `ram_we` are all low.
- R2: A `start` seen in idle makes `busy` high at the next clock edge. The first operation is then a read (`ram_we` low) at address 0.
- R3: Each pass issues the elements E0..E5 in order, one operation per cycle.
  - E0 and E5 are single reads.
  - E1..E4 read an address and write the same address in the following cycle.
  - E0, E1, E2 and E5 step addresses from 0 upward. E3 and E4 step from DEPTH-1 downward.
- R4: In pass two, writes in E1 and E3 carry the bitwise complement of the word held before the test. Writes in E2 and E4 carry that word unchanged.
- R5: Pass one has the same cycle count and addresses as pass two, but `ram_we` stays low throughout.
- R6: Between the passes there is exactly one cycle with `busy` high and `ram_we` low. The signature register is cleared at the start of each pass.
- R7: One cycle after the last pass-two operation, `busy` falls and `done` rises. `fail` is set if the two signatures differ. Both hold until the next accepted `start`.
- R8: After a test on a fault-free RAM, every word holds its pre-test value and `fail` is low.
- R9: A `start` pulse while `busy` is high has no effect on the operation sequence.
- R10: A bit of the RAM stuck at 1 makes `fail` high at the end of the test.
- R11: An accepted `start` clears `done` and `fail`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a test (accepted only when idle) |
| busy | output | 1 | Test in progress |
| done | output | 1 | Test finished, held until the next start |
| fail | output | 1 | Signature mismatch, valid while done |
| ram_addr | output | ADDR_W | RAM address |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | DATA_W | RAM write data |
| ram_rdata | input | DATA_W | RAM read data, combinational from ram_addr |

## Verification
The hard case to reach is a real signature mismatch. A fault-free RAM always yields equal signatures, however its contents are chosen.

The bench's RAM model can force one bit of one word to read as 1. Under that fault the pass-two reads in the elements E2 and E4 differ from the prediction built in pass one. This drives `fail` high.

A clean run follows the fault run. It shows that the next start clears the flag. It also shows that the contents restore again.

// File: rtl/tmb_pkg.sv
package tmb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_PASSEND
    } tmb_state_e;

    localparam logic [2:0] LAST_ELEM = 3'd5;

    // Elements E1..E4 pair a write with their read.
    function automatic logic elem_writes(input logic [2:0] e);
        return (e >= 3'd1) && (e <= 3'd4);
    endfunction

    // E3 and E4 walk the addresses downward.
    function automatic logic elem_down(input logic [2:0] e);
        return (e == 3'd3) || (e == 3'd4);
    endfunction

    // Elements whose read expects the complement of the original word.
    function automatic logic elem_read_inv(input logic [2:0] e);
        return (e == 3'd2) || (e == 3'd4);
    endfunction

    // Elements whose write stores the complement of the original word.
    function automatic logic elem_write_inv(input logic [2:0] e);
        return (e == 3'd1) || (e == 3'd3);
    endfunction

endpackage

// File: rtl/tmb_addr_gen.sv
module tmb_addr_gen #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              load_down,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(DEPTH - 1);

    logic down;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
            down <= 1'b0;
        end else if (load) begin
            down <= load_down;
            addr <= load_down ? TOP_ADDR : '0;
        end else if (step) begin
            addr <= down ? addr - 1'b1 : addr + 1'b1;
        end
    end

    assign last = down ? (addr == '0) : (addr == TOP_ADDR);

    // R3: a step moves exactly one address in the loaded direction
    a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !last) |=>
            (addr == ($past(down) ? $past(addr) - 1'b1 : $past(addr) + 1'b1)));

endmodule

// File: rtl/tmb_misr.sv
module tmb_misr #(
    parameter int         W    = 8,
    parameter logic [W-1:0] POLY = 'h1D
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] sig
);
    logic [W-1:0] sig_nxt;

    always_comb begin
        sig_nxt = {sig[W-2:0], 1'b0} ^ din;
        if (sig[W-1]) sig_nxt = sig_nxt ^ POLY;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   sig <= '0;
        else if (clr) sig <= '0;
        else if (en)  sig <= sig_nxt;
    end

    // R6: the signature starts every pass from zero
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (sig == '0));

endmodule

// File: rtl/tmarch_bist.sv
module tmarch_bist
    import tmb_pkg::*;
#(
    parameter int                DATA_W    = 8,
    parameter int                DEPTH     = 16,
    parameter int                ADDR_W    = $clog2(DEPTH),
    parameter logic [DATA_W-1:0] MISR_POLY = 'h1D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_we,
    output logic [DATA_W-1:0] ram_wdata,
    input  logic [DATA_W-1:0] ram_rdata
);
    tmb_state_e        state, state_n;
    logic              pass;       // 0: prediction pass, 1: real pass
    logic [2:0]        elem;
    logic [DATA_W-1:0] hold;
    logic [DATA_W-1:0] ref_sig;
    logic              done_q, fail_q;

    logic              ag_load, ag_load_down, ag_step, ag_last;
    logic [ADDR_W-1:0] addr;
    logic              elem_inc;
    logic              misr_clr, misr_en;
    logic [DATA_W-1:0] misr_din, sig;

    tmb_addr_gen #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .load(ag_load), .load_down(ag_load_down),
        .step(ag_step), .addr(addr), .last(ag_last)
    );

    tmb_misr #(.W(DATA_W), .POLY(MISR_POLY)) u_misr (
        .clk(clk), .rst_n(rst_n), .clr(misr_clr), .en(misr_en),
        .din(misr_din), .sig(sig)
    );

    // Pass one forms the value pass two should read; pass two compresses raw data.
    assign misr_din = ram_rdata ^ {DATA_W{~pass & elem_read_inv(elem)}};

    // Next-state and sequencing controls
    always_comb begin
        state_n      = state;
        ag_load      = 1'b0;
        ag_load_down = 1'b0;
        ag_step      = 1'b0;
        elem_inc     = 1'b0;
        misr_clr     = 1'b0;
        misr_en      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_n  = ST_READ;
                    ag_load  = 1'b1;
                    misr_clr = 1'b1;
                end
            end
            ST_READ, ST_WRITE: begin
                misr_en = (state == ST_READ);
                if (state == ST_READ && elem_writes(elem)) begin
                    state_n = ST_WRITE;
                end else if (!ag_last) begin
                    state_n = ST_READ;
                    ag_step = 1'b1;
                end else if (elem != LAST_ELEM) begin
                    state_n      = ST_READ;
                    ag_load      = 1'b1;
                    ag_load_down = elem_down(elem + 3'd1);
                    elem_inc     = 1'b1;
                end else begin
                    state_n = ST_PASSEND;
                end
            end
            ST_PASSEND: begin
                if (!pass) begin
                    state_n  = ST_READ;
                    ag_load  = 1'b1;
                    misr_clr = 1'b1;
                end else begin
                    state_n = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pass    <= 1'b0;
            elem    <= '0;
            hold    <= '0;
            ref_sig <= '0;
            done_q  <= 1'b0;
            fail_q  <= 1'b0;
        end else begin
            if (state == ST_IDLE && start) begin
                pass   <= 1'b0;
                elem   <= '0;
                done_q <= 1'b0;
                fail_q <= 1'b0;
            end
            if (state == ST_READ) hold <= ram_rdata;
            if (elem_inc) elem <= elem + 3'd1;
            if (state == ST_PASSEND) begin
                if (!pass) begin
                    ref_sig <= sig;
                    pass    <= 1'b1;
                    elem    <= '0;
                end else begin
                    done_q <= 1'b1;
                    fail_q <= (sig != ref_sig);
                end
            end
        end
    end

    // Outputs: every write of E1..E4 stores the complement of the word just read.
    always_comb begin
        busy      = (state != ST_IDLE);
        done      = done_q;
        fail      = fail_q;
        ram_addr  = addr;
        ram_we    = (state == ST_WRITE) && pass;
        ram_wdata = hold ^ {DATA_W{elem_read_inv(elem) ^ elem_write_inv(elem)}};
    end

    // R3: a write always follows a read of the same address
    a_r3_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> ($past(state) == ST_READ && ram_addr == $past(ram_addr)));

    // R2: an accepted start opens with a read of address 0
    a_r2_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start) |=> (busy && ram_addr == '0 && !ram_we));

    // R7: done is never shown together with busy
    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7: done holds until a start is accepted
    a_r7_done_held: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

endmodule

// File: tb/tmarch_bist_tb.sv
module tmarch_bist_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int DP = 16;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          busy, done, fail, ram_we;
    logic [AW-1:0] ram_addr;
    logic [DW-1:0] ram_wdata, ram_rdata;

    logic [DW-1:0] mem [DP];
    logic          fault_on = 1'b0;
    int            n_checks = 0;
    int            n_fail = 0;

    // Per-element description of the algorithm (E0..E5)
    int el_down [6] = '{0, 0, 0, 1, 1, 0};
    int el_wr   [6] = '{0, 1, 1, 1, 1, 0};
    int el_winv [6] = '{0, 1, 0, 1, 0, 0};

    always #(CLK_PERIOD/2) clk = ~clk;

    tmarch_bist #(.DATA_W(DW), .DEPTH(DP)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .fail(fail), .ram_addr(ram_addr), .ram_we(ram_we),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    // RAM model; optional stuck-at-1 on bit 0 of word 5
    always @(posedge clk) if (ram_we) mem[ram_addr] <= ram_wdata;
    assign ram_rdata = mem[ram_addr] | ((fault_on && ram_addr == 4'd5) ? 8'h01 : 8'h00);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic run_test(input bit flt, input bit exp_fail);
        int qa[$];
        int qw[$];
        int qd[$];
        logic [DW-1:0] orig [DP];
        for (int i = 0; i < DP; i++) orig[i] = mem[i];
        for (int p = 0; p < 2; p++) begin
            for (int e = 0; e < 6; e++) begin
                for (int k = 0; k < DP; k++) begin
                    int a;
                    a = (el_down[e] != 0) ? DP - 1 - k : k;
                    qa.push_back(a); qw.push_back(0); qd.push_back(0);
                    if (el_wr[e] != 0) begin
                        qa.push_back(a);
                        qw.push_back(p);
                        qd.push_back(int'((el_winv[e] != 0) ? ~orig[a] : orig[a]));
                    end
                end
            end
            qa.push_back(-1); qw.push_back(0); qd.push_back(0);   // gap cycle
        end
        fault_on = flt;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        // R11: the accepted start cleared the previous result
        chk(done == 1'b0, "R11 done", int'(done), 0);
        chk(fail == 1'b0, "R11 fail", int'(fail), 0);
        chk(busy == 1'b1 && ram_addr == 0 && ram_we == 1'b0, "R2 first op",
            int'(ram_addr), 0);
        for (int i = 0; i < qa.size(); i++) begin
            if (i > 0) @(negedge clk);
            start = (i == 7);   // R9: start while busy must change nothing
            chk(busy == 1'b1, "R3 busy during test", int'(busy), 1);
            if (qa[i] < 0) begin
                chk(ram_we == 1'b0, "R6 gap cycle", int'(ram_we), 0);
            end else begin
                chk(ram_addr == qa[i][AW-1:0], (i > 7) ? "R3 R9 address" : "R3 address",
                    int'(ram_addr), qa[i]);
                chk(ram_we == qw[i][0], (i < qa.size()/2) ? "R5 write enable" : "R3 write enable",
                    int'(ram_we), qw[i]);
                if (qw[i] == 1 && !flt)
                    chk(ram_wdata == qd[i][DW-1:0], "R4 write data", int'(ram_wdata), qd[i]);
            end
        end
        start = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R7 busy falls", int'(busy), 0);
        chk(done == 1'b1, "R7 done", int'(done), 1);
        chk(fail == exp_fail, flt ? "R10 fault flagged" : "R6 R7 R8 clean result",
            int'(fail), int'(exp_fail));
        repeat (3) @(negedge clk);
        chk(done == 1'b1 && fail == exp_fail, "R7 result held", int'(done), 1);
        if (!flt)
            for (int i = 0; i < DP; i++)
                chk(mem[i] == orig[i], "R8 contents restored", int'(mem[i]), int'(orig[i]));
        fault_on = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < DP; i++) mem[i] = 8'(i * 37 + 11);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(fail == 1'b0, "R1 fail", int'(fail), 0);
        chk(ram_we == 1'b0, "R1 write enable", int'(ram_we), 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_test(1'b0, 1'b0);
        for (int i = 0; i < DP; i++) mem[i] = i[0] ? 8'hFF : 8'h00;
        run_test(1'b0, 1'b0);
        for (int i = 0; i < DP; i++) mem[i] = 8'hA5 ^ 8'(i << 3);
        run_test(1'b1, 1'b1);   // R10
        run_test(1'b0, 1'b0);   // R11 after a failing run
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule